// File: doc/BRIEF.md
# Split-Width General Register File

This block stores the working registers of a small processor core: eight 16-bit registers. Each register can also be reached as two independent 8-bit halves, which gives sixteen byte registers. Two read ports and one write port serve the datapath. Each port chooses a register, an access size (byte or word) and, for byte accesses, which half to use. A byte write changes only the half it addresses. Any register may hold data or an address, and address use always takes the full 16 bits.

The highest-numbered register is also the stack pointer. A separate stack port adjusts it in one cycle. A push moves it down by two before the memory access. A pop moves it up by two after the access. The address the memory access should use is presented on an output in the same cycle. Instruction decode, the ALU and memory access sit outside this block.

Reset does not initialise the storage. A register holds an unknown value until it is first written, and a reset pulse leaves existing contents in place. The block has no state machine: each register is a plain storage element whose next value comes from combinational select logic.

Top module: `gpr_bank`

## Requirements
- R1: A word write (`wr_size`=0) stores all 16 bits of `wr_data` in register `wr_idx`. The new value is readable from the next cycle on.
- R2: A byte write to the high half (`wr_size`=1, `wr_lo`=0) loads `wr_data[7:0]` into bits 15:8 of the register and leaves bits 7:0 unchanged.
- R3: A byte write to the low half (`wr_size`=1, `wr_lo`=1) loads `wr_data[7:0]` into bits 7:0 of the register and leaves bits 15:8 unchanged.
- R4: A byte read (`rX_size`=1) returns the selected half in bits 7:0 and zero in bits 15:8. `rX_lo`=1 selects bits 7:0 of the register and `rX_lo`=0 selects bits 15:8.
- R5: A word read (`rX_size`=0) returns all 16 bits. The two read ports select registers independently in the same cycle.
- R6: A read of a register that is being written in the same cycle returns the value from before the write. There is no bypass.
- R7: Stack operation code 2'b01 (push) lowers register 7 by 2 in one cycle, modulo 2^16. During that cycle `sp_addr` equals the lowered value.
- R8: Stack operation code 2'b10 (pop) raises register 7 by 2 in one cycle, modulo 2^16. During that cycle `sp_addr` equals the value before the pop.
- R9: When the write port targets register 7 in the same cycle as a push or pop, the stack adjustment is applied first and the written half (or the whole word) then replaces the adjusted value.
- R10: A register that is neither written nor adjusted keeps its value. Stack codes 2'b00 and 2'b11 leave register 7 alone, `sp_addr` shows register 7 unchanged, and a reset pulse changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; does not clear storage |
| ra_idx | input | 3 | Read port A register number |
| ra_size | input | 1 | Read port A size: 0 word, 1 byte |
| ra_lo | input | 1 | Read port A half: 1 low, 0 high |
| ra_data | output | 16 | Read port A data |
| rb_idx | input | 3 | Read port B register number |
| rb_size | input | 1 | Read port B size: 0 word, 1 byte |
| rb_lo | input | 1 | Read port B half: 1 low, 0 high |
| rb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register number |
| wr_size | input | 1 | Write size: 0 word, 1 byte |
| wr_lo | input | 1 | Write half: 1 low, 0 high |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| sp_op | input | 2 | Stack code: 00 hold, 01 push, 10 pop, 11 hold |
| sp_addr | output | 16 | Memory address for the current stack operation |

## Verification
The assertions check every cycle that a word write lands whole and that a byte write changes only its own half. They also check that an untouched register stays stable, that a push or pop moves the stack pointer by exactly two, that a push exposes the new top and a pop the old top on `sp_addr`, and that a byte read returns zero in its upper bits. Only the bench's scenarios can show some of the rest. Those are the absence of bypass on a same-cycle read and write, the ordering when a stack adjustment and a write to register 7 collide, wrap-around at both ends of the address range, and contents surviving a reset pulse. The bench also sweeps every register through word, high-byte and low-byte writes and then reads back every word and byte view.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        SP_HOLD  = 2'b00,
        SP_PUSH  = 2'b01,
        SP_POP   = 2'b10,
        SP_IDLE  = 2'b11
    } sp_op_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_size,
    input  logic              rd_lo,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] word_sel;
    logic [HALF_W-1:0] half_sel;

    always_comb begin
        word_sel = regs[rd_idx];
        half_sel = rd_lo ? word_sel[HALF_W-1:0] : word_sel[DATA_W-1:HALF_W];
        unique case (acc_size_e'(rd_size))
            SZ_WORD: rd_data = word_sel;
            SZ_BYTE: rd_data = {{HALF_W{1'b0}}, half_sel};
            default: rd_data = word_sel;
        endcase
    end

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_BYTE) |-> (rd_data[DATA_W-1:HALF_W] == '0)); // R4

endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_size,
    input  logic                wr_lo,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_REGS-1:0] hi_en,
    output logic [NUM_REGS-1:0] lo_en,
    output logic [DATA_W/2-1:0] hi_val,
    output logic [DATA_W/2-1:0] lo_val
);
    localparam int HALF_W = DATA_W / 2;

    logic take_hi;
    logic take_lo;

    always_comb begin
        unique case (acc_size_e'(wr_size))
            SZ_WORD: begin
                take_hi = 1'b1;
                take_lo = 1'b1;
                hi_val  = wr_data[DATA_W-1:HALF_W];
            end
            SZ_BYTE: begin
                take_hi = !wr_lo;
                take_lo = wr_lo;
                hi_val  = wr_data[HALF_W-1:0];
            end
            default: begin
                take_hi = 1'b0;
                take_lo = 1'b0;
                hi_val  = wr_data[DATA_W-1:HALF_W];
            end
        endcase
        lo_val = wr_data[HALF_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        logic hit;
        assign hit      = wr_en && (wr_idx == IDX_W'(g));
        assign hi_en[g] = hit && take_hi;
        assign lo_en[g] = hit && take_lo;
    end

endmodule

// File: rtl/gpr_sp_unit.sv
module gpr_sp_unit
    import gpr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SP_STEP = 2
) (
    input  logic [DATA_W-1:0] sp_cur,
    input  logic [1:0]        sp_op,
    output logic [DATA_W-1:0] sp_adj,
    output logic [DATA_W-1:0] sp_addr
);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(SP_STEP);

    always_comb begin
        unique case (sp_op_e'(sp_op))
            SP_PUSH: begin
                sp_adj  = sp_cur - STEP_W;
                sp_addr = sp_adj;
            end
            SP_POP: begin
                sp_adj  = sp_cur + STEP_W;
                sp_addr = sp_cur;
            end
            SP_HOLD, SP_IDLE: begin
                sp_adj  = sp_cur;
                sp_addr = sp_cur;
            end
            default: begin
                sp_adj  = sp_cur;
                sp_addr = sp_cur;
            end
        endcase
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int SP_STEP  = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic              ra_size,
    input  logic              ra_lo,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              rb_size,
    input  logic              rb_lo,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_size,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        sp_op,
    output logic [DATA_W-1:0] sp_addr
);
    localparam int HALF_W   = DATA_W / 2;
    localparam int SP_INDEX = NUM_REGS - 1;
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(SP_STEP);

    logic [DATA_W-1:0]   gpr_q [NUM_REGS];
    logic [NUM_REGS-1:0] hi_en;
    logic [NUM_REGS-1:0] lo_en;
    logic [HALF_W-1:0]   hi_val;
    logic [HALF_W-1:0]   lo_val;
    logic [DATA_W-1:0]   sp_adj;
    logic                sp_moving;
    logic                sp_written;

    assign sp_moving  = (sp_op == SP_PUSH) || (sp_op == SP_POP);
    assign sp_written = wr_en && (wr_idx == IDX_W'(SP_INDEX));

    gpr_wr_decode #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wr_dec (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_size (wr_size),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .hi_en   (hi_en),
        .lo_en   (lo_en),
        .hi_val  (hi_val),
        .lo_val  (lo_val)
    );

    gpr_sp_unit #(.DATA_W(DATA_W), .SP_STEP(SP_STEP)) u_sp (
        .sp_cur  (gpr_q[SP_INDEX]),
        .sp_op   (sp_op),
        .sp_adj  (sp_adj),
        .sp_addr (sp_addr)
    );

    gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs    (gpr_q),
        .rd_idx  (ra_idx),
        .rd_size (ra_size),
        .rd_lo   (ra_lo),
        .rd_data (ra_data)
    );

    gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs    (gpr_q),
        .rd_idx  (rb_idx),
        .rd_size (rb_size),
        .rd_lo   (rb_lo),
        .rd_data (rb_data)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] base_w;
        logic [DATA_W-1:0] next_w;

        if (g == SP_INDEX) begin : g_sp
            assign base_w = sp_adj;
        end else begin : g_gp
            assign base_w = gpr_q[g];
        end

        always_comb begin
            next_w = base_w;
            if (hi_en[g]) next_w[DATA_W-1:HALF_W] = hi_val;
            if (lo_en[g]) next_w[HALF_W-1:0]      = lo_val;
        end

        // Storage has no reset: contents are unknown until first written.
        always_ff @(posedge clk) begin
            gpr_q[g] <= next_w;
        end

        AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && wr_size == SZ_WORD)
            |=> (gpr_q[g] == $past(wr_data))); // R1

        AST_HI_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && wr_size == SZ_BYTE && !wr_lo
             && ((g != SP_INDEX) || !sp_moving))
            |=> (gpr_q[g][HALF_W-1:0] == $past(gpr_q[g][HALF_W-1:0])
                 && gpr_q[g][DATA_W-1:HALF_W] == $past(wr_data[HALF_W-1:0]))); // R2

        AST_LO_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && wr_size == SZ_BYTE && wr_lo
             && ((g != SP_INDEX) || !sp_moving))
            |=> (gpr_q[g][DATA_W-1:HALF_W] == $past(gpr_q[g][DATA_W-1:HALF_W])
                 && gpr_q[g][HALF_W-1:0] == $past(wr_data[HALF_W-1:0]))); // R3

        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_idx == IDX_W'(g)) && ((g != SP_INDEX) || !sp_moving))
            |=> $stable(gpr_q[g])); // R10
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == SP_PUSH && !sp_written)
        |=> (gpr_q[SP_INDEX] == $past(gpr_q[SP_INDEX]) - STEP_W)); // R7

    AST_PUSH_ADDR_NEW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == SP_PUSH && !sp_written)
        |=> (gpr_q[SP_INDEX] == $past(sp_addr))); // R7

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == SP_POP && !sp_written)
        |=> (gpr_q[SP_INDEX] == $past(gpr_q[SP_INDEX]) + STEP_W)); // R8

    AST_POP_ADDR_OLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == SP_POP) |-> (sp_addr == gpr_q[SP_INDEX])); // R8

endmodule

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic        ra_size = 1'b0, ra_lo = 1'b0, rb_size = 1'b0, rb_lo = 1'b0;
    logic        wr_en = 1'b0, wr_size = 1'b0, wr_lo = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  sp_op = 2'b00;
    logic [15:0] ra_data, rb_data, sp_addr;

    logic [15:0] model [8];
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpr_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_size(ra_size), .ra_lo(ra_lo), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_size(rb_size), .rb_lo(rb_lo), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_lo(wr_lo),
        .wr_data(wr_data), .sp_op(sp_op), .sp_addr(sp_addr)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One clock cycle of write/stack activity; model follows the requirements.
    task automatic cyc(input logic we, input int r, input logic sz, input logic lo,
                       input logic [15:0] d, input logic [1:0] op, input bit chk_addr);
        logic [15:0] sp_t;
        logic [15:0] exp_addr;
        @(negedge clk);
        wr_en = we; wr_idx = 3'(r); wr_size = sz; wr_lo = lo; wr_data = d; sp_op = op;
        #1;
        sp_t = model[7];
        exp_addr = sp_t;
        if (op == 2'b01) begin sp_t = sp_t - 16'd2; exp_addr = sp_t; end
        else if (op == 2'b10) sp_t = sp_t + 16'd2;
        if (chk_addr) check(op == 2'b01 ? "R7 push addr" : (op == 2'b10 ? "R8 pop addr" : "R10 hold addr"),
                            sp_addr, exp_addr);
        @(posedge clk);
        model[7] = sp_t;
        if (we) begin
            if (!sz)     model[r] = d;
            else if (lo) model[r][7:0] = d[7:0];
            else         model[r][15:8] = d[7:0];
        end
        @(negedge clk);
        wr_en = 1'b0; sp_op = 2'b00;
    endtask

    // Read every word view on port A and every byte view on port B.
    task automatic read_all(input string tag);
        for (int r = 0; r < 8; r++) begin
            ra_idx = 3'(r); ra_size = 1'b0; ra_lo = 1'b0;
            rb_idx = 3'(7 - r); rb_size = 1'b1; rb_lo = 1'b0;
            #1;
            check({tag, " R5 word"}, ra_data, model[r]);
            check({tag, " R4 byte hi"}, rb_data, {8'h00, model[7-r][15:8]});
            rb_lo = 1'b1;
            #1;
            check({tag, " R4 byte lo"}, rb_data, {8'h00, model[7-r][7:0]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // Initialise every register while reset is held (reset does not touch storage).
        for (int r = 0; r < 8; r++) cyc(1'b1, r, 1'b0, 1'b0, 16'h1111 * 16'(r) + 16'h0F0F, 2'b00, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("init R1");

        // Sweep: every register, every write kind, three data patterns.
        for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 8; r++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] d;
                    d = 16'((r * 16'h2345) ^ (k * 16'h0B0B) ^ (p * 16'h7E81) ^ 16'hA55A);
                    cyc(1'b1, r, k != 0, k == 2, d, 2'b00, 0);
                    read_all(k == 0 ? "sweep R1" : (k == 1 ? "sweep R2" : "sweep R3"));
                end
            end
        end

        // R6: same-cycle read of the register being written shows the old value.
        @(negedge clk);
        ra_idx = 3'd3; ra_size = 1'b0; rb_idx = 3'd3; rb_size = 1'b1; rb_lo = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd3; wr_size = 1'b0; wr_data = 16'hBEEF;
        #1;
        check("R6 no bypass word", ra_data, model[3]);
        check("R6 no bypass byte", rb_data, {8'h00, model[3][7:0]});
        @(posedge clk); model[3] = 16'hBEEF;
        @(negedge clk); wr_en = 1'b0;
        #1;
        check("R6 after write", ra_data, 16'hBEEF);

        // R7 / R8 basic push and pop, including wrap at both ends.
        cyc(1'b1, 7, 1'b0, 1'b0, 16'h0100, 2'b00, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b01, 1);
        read_all("push R7");
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b10, 1);
        read_all("pop R8");
        cyc(1'b1, 7, 1'b0, 1'b0, 16'h0000, 2'b00, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b01, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R7 push wraps", ra_data, 16'hFFFE);
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b10, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R8 pop wraps", ra_data, 16'h0000);

        // R10: hold codes leave the stack pointer alone.
        cyc(1'b1, 7, 1'b0, 1'b0, 16'h4242, 2'b00, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b11, 1);
        cyc(1'b0, 0, 1'b0, 1'b0, 16'h0, 2'b00, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R10 hold codes", ra_data, 16'h4242);

        // R9: collisions between the stack port and the write port on register 7.
        cyc(1'b1, 7, 1'b0, 1'b0, 16'h1234, 2'b00, 0);
        cyc(1'b1, 7, 1'b1, 1'b1, 16'h00AB, 2'b01, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R9 push + low byte", ra_data, 16'h12AB);
        cyc(1'b1, 7, 1'b1, 1'b0, 16'h00CD, 2'b01, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R9 push + high byte", ra_data, 16'hCDA9);
        cyc(1'b1, 7, 1'b0, 1'b0, 16'h5555, 2'b10, 1);
        ra_idx = 3'd7; ra_size = 1'b0; #1;
        check("R9 pop + word", ra_data, 16'h5555);
        cyc(1'b1, 2, 1'b0, 1'b0, 16'h0C0C, 2'b01, 1);
        read_all("R9 push + other reg");

        // R10: reset pulse leaves contents intact.
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("reset R10");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule